// File: doc/BRIEF.md
# Triggered-FIFO Asynchronous Serial Transmitter

This block serializes bytes onto an asynchronous serial line. Software writes bytes through a one-byte write port into a queue. The queue works either as a single holding register or as a 16-entry FIFO, selected by a mode input. The serializer sends each byte as one frame and raises a transmit-enable interrupt pulse at the moment it begins a frame, so that the next data can be supplied while the current frame is still on the line.

In FIFO mode a programmable trigger count controls two things. It holds off the first frame until enough bytes are queued, and it sets when the refill interrupt fires. Two interrupt timings are offered:
- A "drain" timing fires when the byte just started was the last one waiting.
- A "stride" timing fires after every trigger-sized batch of started bytes. Software then sizes its next burst from the free-space output.

A separate end-of-transmission pulse marks the point where the FIFO has been fully shifted out. The busy flag falls in that same cycle. Bit timing comes from an external baud tick input.

Top module: `uart_trig_tx`

## Requirements
- R1: After reset the serial line is high, busy is low, both interrupt outputs are low, the overflow flag is low and the free-space output reads 16.
- R2: Each frame is 10 bits, each lasting 16 baud ticks: a low start bit, 8 data bits least significant bit first, then a high stop bit. The line is high whenever no frame is in progress.
- R3: With `fifo_mode`=0 the queue holds one byte. A byte starts as soon as the serializer is free. `txe_irq` pulses for one cycle in the first cycle of every frame, which is the cycle the line drops for the start bit.
- R4: A write while the queue is full is dropped. In single mode "full" means one byte held; in FIFO mode it means 16 bytes. A dropped write sets `ovf_flag`, which stays high until reset.
- R5: With `fifo_mode`=1 and no transmission in progress, no frame starts until the occupancy reaches the trigger count. `trig_sel` values 1 to 15 mean that many bytes, and 0 means 16.
- R6: Once a FIFO transmission has started, queued bytes go out in write order with no idle bit time between frames. This continues for as long as data remains, including bytes written after the start.
- R7: In FIFO mode with `itm_stride`=0, `txe_irq` pulses at the start of a frame only if that frame's byte was the last one in the FIFO.
- R8: In FIFO mode with `itm_stride`=1, `txe_irq` pulses at the start of every trigger-count-th frame, counted from the start of the current transmission.
- R9: In FIFO mode, `tend_irq` pulses for one cycle when a frame ends with nothing left to send, and `busy` falls in that same cycle. In single mode `tend_irq` never pulses.
- R10: `free_cnt` equals 16 minus the queue occupancy. It reflects each accepted write and each byte taken by the serializer from the cycle after that event.
- R11: `busy` is high during every cycle in which a frame is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_mode | input | 1 | 0 = single holding register, 1 = 16-byte FIFO |
| itm_stride | input | 1 | FIFO interrupt timing: 0 = drain, 1 = stride |
| trig_sel | input | 4 | Trigger count (0 encodes 16) |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| tx_o | output | 1 | Serial line |
| txe_irq | output | 1 | Transmit-enable interrupt pulse |
| tend_irq | output | 1 | FIFO transmission-end interrupt pulse |
| busy | output | 1 | Frame in progress |
| free_cnt | output | 5 | Free queue entries |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
Some properties are checked on every cycle:
- occupancy steps on each accepted write;
- a dropped write sets the overflow flag;
- the idle line stays high;
- the serializer never takes from an empty queue;
- no FIFO transmission opens below the trigger count;
- the transmit-enable pulse coincides with a start bit;
- the end pulse coincides with busy falling.

Other behaviour can only be shown by the scenarios, because it depends on the history of a whole sequence:
- the decoded byte order and LSB-first bit order;
- the absence of gaps between frames;
- which frames of a burst carry an interrupt under the drain and stride timings;
- the 0-means-16 trigger decoding.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned Q_DEPTH    = 16;
endpackage

// File: rtl/txq_buffer.sv
module txq_buffer #(
    parameter int unsigned DEPTH = uart_trig_pkg::Q_DEPTH,
    parameter int unsigned DW    = uart_trig_pkg::DATA_BITS,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             single_mode,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             pop,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    typedef struct packed {
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0] cap;
    logic push;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap  = single_mode ? CNT_W'(1) : CNT_W'(DEPTH);
        push = wr_en && (st_q.count < cap);
        st_d = st_q;
        if (push) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        if (push && !pop)      st_d.count = st_q.count + 1'b1;
        else if (!push && pop) st_d.count = st_q.count - 1'b1;
        if (wr_en && !push) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr_ptr] <= wr_data;
    end

    assign rd_data = mem_q[st_q.rd_ptr];
    assign count   = st_q.count;
    assign ovf     = st_q.ovf;

    p_push_grows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (st_q.count == CNT_W'($past(st_q.count) + 1'b1)));
    p_drop_sets_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !push) |=> st_q.ovf);
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.count != '0));
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int unsigned DW = uart_trig_pkg::DATA_BITS,
    parameter int unsigned OS = uart_trig_pkg::OVERSAMPLE,
    localparam int unsigned FRAME = DW + 2,
    localparam int unsigned BW    = $clog2(FRAME),
    localparam int unsigned TW    = $clog2(OS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          tx_o,
    output logic          active,
    output logic          ready,
    output logic          frame_end
);
    typedef struct packed {
        logic             active;
        logic [TW-1:0]    tick;
        logic [BW-1:0]    bitn;
        logic [FRAME-1:0] shreg;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        frame_end = st_q.active && baud_tick && (st_q.tick == TW'(OS - 1))
                    && (st_q.bitn == BW'(FRAME - 1));
        ready = !st_q.active || frame_end;
        st_d  = st_q;
        if (st_q.active && baud_tick) begin
            if (st_q.tick == TW'(OS - 1)) begin
                st_d.tick = '0;
                if (st_q.bitn == BW'(FRAME - 1)) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.bitn  = st_q.bitn + 1'b1;
                    st_d.shreg = {1'b1, st_q.shreg[FRAME-1:1]};
                end
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end
        if (load) begin
            st_d.active = 1'b1;
            st_d.tick   = '0;
            st_d.bitn   = '0;
            st_d.shreg  = {1'b1, load_data, 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{active: 1'b0, tick: '0, bitn: '0, shreg: '1};
        else        st_q <= st_d;
    end

    assign tx_o   = st_q.active ? st_q.shreg[0] : 1'b1;
    assign active = st_q.active;

    p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> tx_o);
    p_load_only_when_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ready);
endmodule

// File: rtl/tx_launch_ctrl.sv
module tx_launch_ctrl #(
    parameter int unsigned DEPTH = uart_trig_pkg::Q_DEPTH,
    localparam int unsigned TRW   = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic             itm_stride,
    input  logic [TRW-1:0]   trig_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             ready,
    input  logic             frame_end,
    output logic             load,
    output logic             txe_irq,
    output logic             tend_irq
);
    typedef struct packed {
        logic             sess;
        logic [CNT_W-1:0] grp;
        logic             txe;
        logic             tend;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic [CNT_W-1:0] trig_n;
    logic [CNT_W-1:0] grp_next;
    logic start_ok, stride_hit, drain_hit;

    always_comb begin
        trig_n = (trig_sel == '0) ? CNT_W'(DEPTH) : CNT_W'(trig_sel);
        if (!fifo_mode)      start_ok = (count != '0);
        else if (st_q.sess)  start_ok = (count != '0);
        else                 start_ok = (count >= trig_n);
        load       = ready && start_ok;
        grp_next   = (st_q.sess ? st_q.grp : '0) + 1'b1;
        stride_hit = (grp_next == trig_n);
        drain_hit  = (count == CNT_W'(1));

        st_d      = st_q;
        st_d.txe  = load && (!fifo_mode || (itm_stride ? stride_hit : drain_hit));
        st_d.tend = fifo_mode && frame_end && !load;
        if (load && fifo_mode) begin
            st_d.sess = 1'b1;
            st_d.grp  = stride_hit ? '0 : grp_next;
        end else if (frame_end) begin
            st_d.sess = 1'b0;
            st_d.grp  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign txe_irq  = st_q.txe;
    assign tend_irq = st_q.tend;

    p_trig_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && fifo_mode && !st_q.sess) |-> (count >= trig_n));
    p_txe_follows_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.txe |-> $past(load));
endmodule

// File: rtl/uart_trig_tx.sv
module uart_trig_tx #(
    parameter int unsigned DEPTH = uart_trig_pkg::Q_DEPTH,
    parameter int unsigned DW    = uart_trig_pkg::DATA_BITS,
    parameter int unsigned OS    = uart_trig_pkg::OVERSAMPLE,
    localparam int unsigned TRW   = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             fifo_mode,
    input  logic             itm_stride,
    input  logic [TRW-1:0]   trig_sel,
    input  logic             baud_tick,
    output logic             tx_o,
    output logic             txe_irq,
    output logic             tend_irq,
    output logic             busy,
    output logic [CNT_W-1:0] free_cnt,
    output logic             ovf_flag
);
    logic [CNT_W-1:0] occ;
    logic [DW-1:0]    head;
    logic             load, ready, frame_end;

    txq_buffer #(.DEPTH(DEPTH), .DW(DW)) q_i (
        .clk(clk), .rst_n(rst_n), .single_mode(!fifo_mode),
        .wr_en(wr_en), .wr_data(wr_data), .pop(load),
        .rd_data(head), .count(occ), .ovf(ovf_flag)
    );

    tx_launch_ctrl #(.DEPTH(DEPTH)) ctl_i (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .itm_stride(itm_stride),
        .trig_sel(trig_sel), .count(occ), .ready(ready), .frame_end(frame_end),
        .load(load), .txe_irq(txe_irq), .tend_irq(tend_irq)
    );

    tx_shifter #(.DW(DW), .OS(OS)) sh_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
        .load_data(head), .tx_o(tx_o), .active(busy), .ready(ready),
        .frame_end(frame_end)
    );

    assign free_cnt = CNT_W'(DEPTH) - occ;

    p_tend_drops_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tend_irq |-> (!busy && $past(busy)));
    p_txe_at_start_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txe_irq |-> (busy && !tx_o));
    p_tend_fifo_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tend_irq |-> fifo_mode);
endmodule

// File: tb/uart_trig_tx_tb_top.sv
module uart_trig_tx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic fifo_mode = 1'b0;
    logic itm_stride = 1'b0;
    logic [3:0] trig_sel = 4'd1;
    logic baud_tick = 1'b1;
    logic tx_o, txe_irq, tend_irq, busy, ovf_flag;
    logic [4:0] free_cnt;

    always #2.5 clk = ~clk;

    uart_trig_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .itm_stride(itm_stride), .trig_sel(trig_sel),
        .baud_tick(baud_tick), .tx_o(tx_o), .txe_irq(txe_irq), .tend_irq(tend_irq),
        .busy(busy), .free_cnt(free_cnt), .ovf_flag(ovf_flag)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rx_n = 0, txe_n = 0, tend_n = 0;
    int rx_d [64];
    int rx_t [64];
    int txe_t [64];
    int tend_t [16];
    int busy_gap = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (txe_irq && txe_n < 64) begin txe_t[txe_n] = cyc; txe_n++; end
            if (tend_irq && tend_n < 16) begin tend_t[tend_n] = cyc; tend_n++; end
        end
    end

    // line decoder: samples the middle of each bit (16 cycles per bit)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_o == 1'b0) begin
                int st;
                logic [7:0] b;
                st = cyc;
                repeat (7) begin
                    @(negedge clk);
                    if (!busy) busy_gap++;
                end
                for (int i = 0; i < 8; i++) begin
                    repeat (16) begin
                        @(negedge clk);
                        if (!busy) busy_gap++;
                    end
                    b[i] = tx_o;
                end
                repeat (16) @(negedge clk);
                if (tx_o !== 1'b1) begin
                    errors++; checks++;
                    $display("FAIL R2 stop bit: actual=%b expected=1", tx_o);
                end
                if (rx_n < 64) begin rx_d[rx_n] = b; rx_t[rx_n] = st; rx_n++; end
                repeat (7) @(negedge clk);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic fm, input logic stride, input logic [3:0] tr);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        fifo_mode = fm; itm_stride = stride; trig_sel = tr;
        repeat (3) @(negedge clk);
        rx_n = 0; txe_n = 0; tend_n = 0; busy_gap = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int k = 0; k < 6000 && rx_n < n; k++) @(negedge clk);
        repeat (200) @(negedge clk);
    endtask

    task automatic check_gapless(input int n, input string tag);
        for (int i = 1; i < n; i++)
            chk(rx_t[i] - rx_t[i-1] == 160, tag, rx_t[i] - rx_t[i-1], 160);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b0, 4'd1);
        chk(tx_o == 1'b1, "R1 line idle", tx_o, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(txe_irq == 1'b0 && tend_irq == 1'b0, "R1 irqs", txe_irq + tend_irq, 0);
        chk(ovf_flag == 1'b0, "R1 ovf", ovf_flag, 0);
        chk(free_cnt == 5'd16, "R1 free_cnt", free_cnt, 16);
    endtask

    task automatic t_single;
        do_reset(1'b0, 1'b0, 4'd3);
        wr(8'hA5);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R11 busy during frame", busy, 1);
        wr(8'h3C);
        chk(free_cnt == 5'd15, "R10 free after hold", free_cnt, 15);
        wr(8'hFF);
        chk(ovf_flag == 1'b1, "R4 single drop sets ovf", ovf_flag, 1);
        wait_rx(2);
        chk(rx_n == 2, "R4 dropped byte not sent", rx_n, 2);
        chk(rx_d[0] == 8'hA5, "R2 byte0 LSB first", rx_d[0], 8'hA5);
        chk(rx_d[1] == 8'h3C, "R3 byte1", rx_d[1], 8'h3C);
        check_gapless(2, "R3 back-to-back");
        chk(txe_n == 2, "R3 txe per frame", txe_n, 2);
        chk(txe_t[0] == rx_t[0] && txe_t[1] == rx_t[1], "R3 txe at start bit",
            txe_t[1], rx_t[1]);
        chk(tend_n == 0, "R9 no tend in single mode", tend_n, 0);
        chk(busy_gap == 0, "R11 busy in frames", busy_gap, 0);
        chk(ovf_flag == 1'b1, "R4 ovf sticky", ovf_flag, 1);
    endtask

    task automatic t_fifo_drain;
        do_reset(1'b1, 1'b0, 4'd4);
        wr(8'h11); wr(8'h22); wr(8'h33);
        repeat (50) @(negedge clk);
        chk(rx_n == 0 && busy == 1'b0, "R5 held below trigger", rx_n + busy, 0);
        chk(free_cnt == 5'd13, "R10 free after three", free_cnt, 13);
        wr(8'h44);
        wait_rx(4);
        chk(rx_n == 4, "R6 count", rx_n, 4);
        for (int i = 0; i < 4; i++)
            chk(rx_d[i] == 8'h11 * (i + 1), "R6 order", rx_d[i], 8'h11 * (i + 1));
        check_gapless(4, "R6 gapless");
        chk(txe_n == 1, "R7 drain pulse count", txe_n, 1);
        chk(txe_t[0] == rx_t[3], "R7 drain pulse on last byte", txe_t[0], rx_t[3]);
        chk(tend_n == 1, "R9 tend count", tend_n, 1);
        chk(tend_t[0] == rx_t[3] + 160, "R9 tend timing", tend_t[0], rx_t[3] + 160);
        chk(busy == 1'b0 && free_cnt == 5'd16, "R9 idle after end", busy, 0);
        chk(ovf_flag == 1'b0, "R4 no ovf without drop", ovf_flag, 0);
    endtask

    task automatic t_fifo_stride;
        do_reset(1'b1, 1'b1, 4'd2);
        for (int i = 0; i < 5; i++) wr(8'h80 | 8'(i));
        wait_rx(5);
        chk(rx_n == 5, "R6 stride count", rx_n, 5);
        for (int i = 0; i < 5; i++)
            chk(rx_d[i] == (8'h80 | i), "R6 stride order", rx_d[i], 8'h80 | i);
        check_gapless(5, "R6 stride gapless");
        chk(txe_n == 2, "R8 stride pulses", txe_n, 2);
        chk(txe_t[0] == rx_t[1] && txe_t[1] == rx_t[3], "R8 stride positions",
            txe_t[1], rx_t[3]);
        chk(tend_n == 1, "R9 stride tend", tend_n, 1);
    endtask

    task automatic t_fifo_full16;
        do_reset(1'b1, 1'b0, 4'd0);
        for (int i = 0; i < 15; i++) wr(8'(i + 1));
        repeat (30) @(negedge clk);
        chk(rx_n == 0 && busy == 1'b0, "R5 zero means sixteen", rx_n + busy, 0);
        wr(8'd16);
        chk(free_cnt == 5'd0, "R10 full", free_cnt, 0);
        wr(8'hEE);
        chk(ovf_flag == 1'b1, "R4 fifo full drop", ovf_flag, 1);
        wait_rx(16);
        chk(rx_n == 16, "R4 extra byte not sent", rx_n, 16);
        chk(rx_d[15] == 16, "R6 last byte", rx_d[15], 16);
        check_gapless(16, "R6 sixteen gapless");
        chk(txe_n == 1 && txe_t[0] == rx_t[15], "R7 drain at sixteenth", txe_n, 1);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_single;
                t_fifo_drain;
                t_fifo_stride;
                t_fifo_full16;
            end
            begin
                repeat (150000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule